// File: doc/BRIEF.md
# Fault-Tolerant SPI Slave Frame Engine

This block is the receive/transmit core of an SPI slave. Serial clock, select and data-in are brought into the system clock domain through a synchronizer and an edge detector. A small sequencer counts sampling edges and moves a transmit shift register and a receive shift register. Clock polarity and phase are chosen by two configuration inputs. The frame length, from 1 bit up to `MAX_BITS`, is given as length minus one. At the end of each frame the received word appears on a registered output with a one-cycle valid pulse.

Behaviour under protocol faults is fully defined. The frame is committed at the first serial clock edge seen while select is active. After that, withdrawing select does not abort the frame: further clocks complete it and the word is still delivered. If the serial clock stops, the engine freezes its bit position and partial data for any length of time, because it has no timer. A select pulse that carries no clock edge starts nothing. A master that has lost alignment can therefore clock exactly one frame length to bring the engine back to a frame boundary.

The transmit word is written into a holding register with a load strobe. A frame takes a copy of it at the frame's first edge, so a load that arrives during a frame only affects the next frame.

Top module: `fts_spi_slave`

## Requirements
- R1: Once a frame has started, raising `spi_ss_n` does not abort it. The remaining serial clocks still shift bits, and after the last one the word is delivered with one `rx_valid` pulse.
- R2: While no serial clock edge arrives, the bit count, the partial receive data and the frame state hold for any number of cycles. A frame stalled for 3000 system cycles resumes at the next bit and ends with the correct word.
- R3: If `spi_ss_n` is low for a while and then rises without any serial clock edge, no frame starts and no `rx_valid` pulse follows. Serial clock edges while idle with `spi_ss_n` high are also ignored.
- R4: A frame ends after exactly `cfg_len_m1`+1 sampling edges, and the engine then returns to idle. With `spi_ss_n` held low, back-to-back frames each deliver their own word.
- R5: Data is MSB first. The first bit sampled lands at bit `cfg_len_m1` of `rx_word`, the last bit lands at bit 0, and the bits above the frame length read 0.
- R6: `rx_valid` is a single-cycle pulse, one per completed frame, and `rx_word` holds its value until the next frame completes. After reset, `rx_valid`, `rx_word` and `spi_miso` are 0.
- R7: The idle level of the serial clock is `cfg_cpol`. The leading edge is the first edge away from that level. With `cfg_cpha`=0, data is sampled on leading edges and launched on trailing edges. With `cfg_cpha`=1, data is launched on leading edges and sampled on trailing edges.
- R8: `spi_miso` sends bits `cfg_len_m1` down to 0 of the transmit word. With `cfg_cpha`=0, the MSB is already present before the first edge. Within a frame, `spi_miso` changes only after launch edges.
- R9: `tx_load` writes `tx_word` into the holding register. A load during a frame, including a load in the cycle the frame starts, takes effect from the next frame. A select pulse with no clock leaves the loaded word unchanged for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_len_m1 | input | $clog2(MAX_BITS) | Frame length minus one |
| tx_word | input | MAX_BITS | Transmit word, right aligned |
| tx_load | input | 1 | Write `tx_word` into the holding register |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| rx_word | output | MAX_BITS | Last received word, right aligned |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |

## Verification
Two functions can land in the same system cycle: the start of a frame, when the holding register is copied, and a write to that holding register through `tx_load`. The bench counts the synchronizer and edge-detector latency from the moment it drives the first leading edge, and pulses `tx_load` in exactly the cycle the engine registers the start. The collision is judged at the serial pins. The frame in progress must carry the old word on `spi_miso`, and the following frame, with no further load, must carry the new one. Select release and frame completion are also made to interleave, by raising select partway through a frame and clocking the frame out.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic {
    FR_IDLE  = 1'b0,
    FR_SHIFT = 1'b1
  } frame_state_e;

  typedef struct packed {
    logic lead;
    logic trail;
  } sclk_edges_t;

endpackage

// File: rtl/fts_sync.sv
module fts_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stg;
      always_ff @(posedge clk) begin
        if (rst) stg <= RST_VAL;
        else     stg <= d;
      end
      assign q = stg;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk) begin
        if (rst) stg <= {STAGES{RST_VAL}};
        else     stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/fts_edge.sv
module fts_edge
  import fts_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cpol,
  input  logic        lvl,
  output sclk_edges_t edges
);

  logic lvl_d;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  always_comb begin
    rise        = lvl & ~lvl_d;
    fall        = ~lvl & lvl_d;
    edges.lead  = cpol ? fall : rise;
    edges.trail = cpol ? rise : fall;
  end

endmodule

// File: rtl/fts_seq.sv
module fts_seq
  import fts_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int CW = $clog2(MAX_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpha,
  input  logic          sel,
  input  sclk_edges_t   edges,
  input  logic [CW-1:0] len_m1,
  output logic          start,
  output logic          sample,
  output logic          launch,
  output logic          done,
  output logic          active,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] len_q
);

  frame_state_e  st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_base;
  logic [CW-1:0] len_eff;
  logic          sample_ev;
  logic          launch_ev;

  assign active = (st_q == FR_SHIFT);
  assign cnt    = cnt_q;

  always_comb begin
    sample_ev = cpha ? edges.trail : edges.lead;
    launch_ev = cpha ? edges.lead  : edges.trail;
    start     = ~active & sel & edges.lead;
    sample    = (start & ~cpha) | (active & sample_ev);
    launch    = active & launch_ev;
    cnt_base  = start ? '0 : cnt_q;
    len_eff   = start ? len_m1 : len_q;
    done      = sample & (cnt_base == len_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= FR_IDLE;
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      if (start) len_q <= len_m1;
      if (sample) cnt_q <= done ? '0 : cnt_base + 1'b1;
      else if (start) cnt_q <= '0;
      if (done) st_q <= FR_IDLE;
      else if (start) st_q <= FR_SHIFT;
    end
  end

endmodule

// File: rtl/fts_spi_slave.sv
module fts_spi_slave
  import fts_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_cpol,
  input  logic                        cfg_cpha,
  input  logic [$clog2(MAX_BITS)-1:0] cfg_len_m1,
  input  logic [MAX_BITS-1:0]         tx_word,
  input  logic                        tx_load,
  input  logic                        spi_sclk,
  input  logic                        spi_ss_n,
  input  logic                        spi_mosi,
  output logic                        spi_miso,
  output logic [MAX_BITS-1:0]         rx_word,
  output logic                        rx_valid
);

  localparam int CW = $clog2(MAX_BITS);
  localparam int PADW = CW + 1;
  localparam logic [PADW-1:0] TOP_IDX = PADW'(MAX_BITS - 1);

  logic [2:0]          pins_s;
  logic                sclk_s;
  logic                ssn_s;
  logic                mosi_s;
  sclk_edges_t         edges_w;
  logic                start_w;
  logic                sample_w;
  logic                launch_w;
  logic                done_w;
  logic                active_w;
  logic [CW-1:0]       cnt_w;
  logic [CW-1:0]       len_q_w;
  logic [MAX_BITS-1:0] hold_q;
  logic [MAX_BITS-1:0] tx_sr;
  logic [MAX_BITS-1:0] rx_sr;
  logic [MAX_BITS-1:0] rx_base;
  logic [MAX_BITS-1:0] rx_next;
  logic [MAX_BITS-1:0] aligned;
  logic [PADW-1:0]     pad;

  fts_sync #(
    .W(3),
    .STAGES(SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({spi_sclk, spi_ss_n, spi_mosi}),
    .q  (pins_s)
  );

  assign sclk_s = pins_s[2];
  assign ssn_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  fts_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .cpol (cfg_cpol),
    .lvl  (sclk_s),
    .edges(edges_w)
  );

  fts_seq #(
    .MAX_BITS(MAX_BITS),
    .CW(CW)
  ) u_seq (
    .clk   (clk),
    .rst   (rst),
    .cpha  (cfg_cpha),
    .sel   (~ssn_s),
    .edges (edges_w),
    .len_m1(cfg_len_m1),
    .start (start_w),
    .sample(sample_w),
    .launch(launch_w),
    .done  (done_w),
    .active(active_w),
    .cnt   (cnt_w),
    .len_q (len_q_w)
  );

  always_comb begin
    pad     = TOP_IDX - {1'b0, cfg_len_m1};
    aligned = hold_q << pad;
    rx_base = start_w ? '0 : rx_sr;
    rx_next = (rx_base << 1) | {{(MAX_BITS-1){1'b0}}, mosi_s};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (tx_load) hold_q <= tx_word;
      if (launch_w) tx_sr <= tx_sr << 1;
      else if (!active_w) tx_sr <= aligned;
      if (sample_w) rx_sr <= rx_next;
      else if (start_w) rx_sr <= '0;
      rx_valid <= done_w;
      if (done_w) rx_word <= rx_next;
    end
  end

  assign spi_miso = tx_sr[MAX_BITS-1];

endmodule

// File: rtl/fts_spi_slave_chk.sv
module fts_spi_slave_chk #(
  parameter int MAX_BITS = 32,
  parameter int CW = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                lead,
  input logic                trail,
  input logic                active,
  input logic                done,
  input logic [CW-1:0]       cnt,
  input logic [CW-1:0]       len_q,
  input logic [MAX_BITS-1:0] rx_sr,
  input logic                spi_miso,
  input logic                rx_valid
);

  AST_MIDFRAME_RUNS: assert property (@(posedge clk) disable iff (rst)
    (active && !done) |=> active); // R1

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!lead && !trail) |=> ($stable(cnt) && $stable(active) && $stable(rx_sr))); // R2

  AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!active && !lead) |=> !active); // R3

  AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (rst)
    (!active && !lead) |=> !rx_valid); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= len_q)); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R6

  AST_MISO_STEADY: assert property (@(posedge clk) disable iff (rst)
    (active && !lead && !trail) |=> $stable(spi_miso)); // R8

endmodule

bind fts_spi_slave fts_spi_slave_chk #(
  .MAX_BITS(MAX_BITS),
  .CW($clog2(MAX_BITS))
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .lead    (edges_w.lead),
  .trail   (edges_w.trail),
  .active  (active_w),
  .done    (done_w),
  .cnt     (cnt_w),
  .len_q   (len_q_w),
  .rx_sr   (rx_sr),
  .spi_miso(spi_miso),
  .rx_valid(rx_valid)
);

// File: tb/sim_fts_spi_slave.sv
module sim_fts_spi_slave;

  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpol;
  logic        cpha;
  logic [4:0]  len_m1;
  logic [31:0] tx_word;
  logic        tx_load;
  logic        sclk;
  logic        ss_n;
  logic        mosi;
  logic        miso;
  logic [31:0] rx_word;
  logic        rx_valid;

  int          nchk = 0;
  int          nfail = 0;
  int          vcount = 0;
  logic [31:0] last_rx = '0;
  logic [31:0] got = '0;

  always #10 clk = ~clk;

  fts_spi_slave #(.MAX_BITS(32), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_len_m1(len_m1),
    .tx_word(tx_word), .tx_load(tx_load), .spi_sclk(sclk), .spi_ss_n(ss_n),
    .spi_mosi(mosi), .spi_miso(miso), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  always @(posedge clk) begin
    if (!rst && rx_valid) begin
      vcount <= vcount + 1;
      last_rx <= rx_word;
    end
  end

  function automatic logic [31:0] msk(int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic load(logic [31:0] w);
    @(negedge clk);
    tx_word = w;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  // Pulse tx_load in the cycle the engine registers the frame start:
  // two synchronizer stages after the pin edge, sampled at the third edge.
  task automatic late_load(logic [31:0] w);
    repeat (2) @(negedge clk);
    tx_word = w;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic run_bits(int from, int to, int len, logic [31:0] mo,
                          bit col, logic [31:0] cw);
    for (int k = from; k < to; k++) begin
      int b;
      b = len - 1 - k;
      if (!cpha) begin
        mosi = mo[b];
        half();
        got[b] = miso;
        sclk = ~cpol;
        if (col && k == from) fork late_load(cw); join_none
        half();
        sclk = cpol;
      end else begin
        sclk = ~cpol;
        if (col && k == from) fork late_load(cw); join_none
        mosi = mo[b];
        half();
        got[b] = miso;
        sclk = cpol;
        half();
      end
    end
    if (!cpha) half();
  endtask

  task automatic set_mode(bit p, bit h, int len);
    @(negedge clk);
    ss_n = 1'b1;
    cpol = p;
    cpha = h;
    sclk = p;
    len_m1 = 5'(len - 1);
    repeat (10) @(negedge clk);
  endtask

  task automatic full_frame(int len, logic [31:0] mo, logic [31:0] txw, string tag,
                            bit col, logic [31:0] cw);
    int v0;
    got = '0;
    v0 = vcount;
    @(negedge clk);
    ss_n = 1'b0;
    half();
    run_bits(0, len, len, mo, col, cw);
    @(negedge clk);
    ss_n = 1'b1;
    repeat (12) @(negedge clk);
    chk({tag, " R6 one pulse"}, 32'(vcount - v0), 32'd1);
    chk({tag, " R5 rx word"}, last_rx, mo & msk(len));
    chk({tag, " R8 miso bits"}, got & msk(len), txw & msk(len));
  endtask

  function automatic int len_of(int i);
    case (i)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 8;
      4: return 13;
      5: return 16;
      6: return 31;
      default: return 32;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; cpol = 1'b0; cpha = 1'b0; len_m1 = '0;
    tx_word = '0; tx_load = 1'b0; sclk = 1'b0; ss_n = 1'b1; mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 reset rx_valid", 32'(rx_valid), 32'd0);
    chk("R6 reset rx_word", rx_word, 32'd0);
    chk("R6 reset miso", 32'(miso), 32'd0);

    // R7 sweep over every mode and a spread of frame lengths
    for (int m = 0; m < 4; m++) begin
      for (int li = 0; li < 8; li++) begin
        int len;
        int v0;
        logic [31:0] txw;
        logic [31:0] mo;
        string tag;
        len = len_of(li);
        txw = (32'hA5C3_0F1E ^ (32'(m) * 32'h0101_0101)) + 32'(li) * 32'h1357_9BDF;
        mo  = ~txw ^ (32'(li + m) * 32'h0F1E_2D3C);
        tag = $sformatf("R7 mode%0d len%0d", m, len);
        v0 = vcount;
        set_mode(m[1], m[0], len);
        chk({tag, " R3 idle edges ignored"}, 32'(vcount - v0), 32'd0);
        load(txw);
        full_frame(len, mo, txw, tag, 1'b0, '0);
      end
    end

    // Fault scenarios in modes 0 and 3, 12-bit frames
    for (int mi = 0; mi < 2; mi++) begin
      int v0;
      bit p;
      logic [31:0] wa;
      logic [31:0] wb;
      p = (mi == 1);
      set_mode(p, p, 12);

      // R1: select withdrawn after 5 bits, frame clocked to the end
      wa = 32'h0000_0A5C + 32'(mi);
      load(wa);
      got = '0; v0 = vcount;
      @(negedge clk); ss_n = 1'b0; half();
      run_bits(0, 5, 12, 32'h0000_0C3B, 1'b0, '0);
      @(negedge clk); ss_n = 1'b1;
      run_bits(5, 12, 12, 32'h0000_0C3B, 1'b0, '0);
      repeat (12) @(negedge clk);
      chk("R1 word after select drop", 32'(vcount - v0), 32'd1);
      chk("R1 rx word", last_rx, 32'h0000_0C3B);
      chk("R1 miso bits", got & msk(12), wa & msk(12));

      // R2: clock stall mid-frame
      wb = 32'h0000_05E1 ^ 32'(mi);
      load(wb);
      got = '0; v0 = vcount;
      @(negedge clk); ss_n = 1'b0; half();
      run_bits(0, 6, 12, 32'h0000_09A6, 1'b0, '0);
      repeat (3000) @(negedge clk);
      chk("R2 no word during stall", 32'(vcount - v0), 32'd0);
      run_bits(6, 12, 12, 32'h0000_09A6, 1'b0, '0);
      @(negedge clk); ss_n = 1'b1;
      repeat (12) @(negedge clk);
      chk("R2 word after resume", 32'(vcount - v0), 32'd1);
      chk("R2 rx word", last_rx, 32'h0000_09A6);
      chk("R2 miso bits", got & msk(12), wb & msk(12));

      // R3: select pulse with no clock, then clocks with select high
      wa = 32'h0000_0B72 + 32'(mi);
      load(wa);
      v0 = vcount;
      @(negedge clk); ss_n = 1'b0;
      repeat (40) @(negedge clk);
      ss_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R3 select without clock", 32'(vcount - v0), 32'd0);
      for (int t = 0; t < 24; t++) begin
        sclk = ~sclk;
        half();
      end
      chk("R3 clocks with select high", 32'(vcount - v0), 32'd0);
      full_frame(12, 32'h0000_0E19, wa, "R9 untouched word", 1'b0, '0);

      // R4: back-to-back frames with select held low, load during frame 1
      wa = 32'h0000_0D2C ^ 32'(mi);
      wb = 32'h0000_0367 + 32'(mi);
      load(wa);
      got = '0; v0 = vcount;
      @(negedge clk); ss_n = 1'b0; half();
      fork
        run_bits(0, 12, 12, 32'h0000_0F0F, 1'b0, '0);
        begin repeat (40) @(negedge clk); load(wb); end
      join
      chk("R4 first frame word count", 32'(vcount - v0), 32'd1);
      chk("R4 first frame rx", last_rx, 32'h0000_0F0F);
      chk("R9 mid-frame load no effect", got & msk(12), wa & msk(12));
      got = '0;
      run_bits(0, 12, 12, 32'h0000_0871, 1'b0, '0);
      @(negedge clk); ss_n = 1'b1;
      repeat (12) @(negedge clk);
      chk("R4 second frame word count", 32'(vcount - v0), 32'd2);
      chk("R4 second frame rx", last_rx, 32'h0000_0871);
      chk("R9 next frame sends new word", got & msk(12), wb & msk(12));

      // R9: load in the exact frame-start cycle
      wa = 32'h0000_0ACE;
      wb = 32'h0000_0531 ^ 32'(mi);
      load(wa);
      full_frame(12, 32'h0000_0246, wa, "R9 collision current", 1'b1, wb);
      full_frame(12, 32'h0000_0DB9, wb, "R9 collision next", 1'b0, '0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule